// File: doc/BRIEF.md
# I2C Master Receive Engine

This block is the receive half of an I2C master. Once the address phase is over (handled elsewhere), it generates SCL and clocks data bytes in from a slave. It returns the acknowledge bit and parks the bus by holding SCL low at a point software can choose. At each park point it raises a one-cycle interrupt. While parked, software can read the received byte, change the acknowledge response, move the next park point, and then either resume with a release strobe or request a stop condition.

The stop sequence works in three steps:

- It pulls SDA low while SCL is low.
- It lets go of SCL and waits until the synchronized SCL level is really high. A slave may still be stretching the clock at this point.
- It keeps SDA low for a setup time counted in system clocks, chosen by the speed-mode input, and then releases SDA.

The bus pins are modelled as open-drain pull-down enables: the outputs pull the bus low, and the inputs sample the wired bus level.

Top module: `iic_mrx_engine`

## Requirements
- R1: With `wait_ack_i`=0, after the falling edge of the DATA_W-th clock the engine keeps SCL pulled low and pulses `irq_o` for one cycle. `rx_data_o` then holds the byte, sampled on SCL rising edges with the first received bit in bit DATA_W-1 (MSB first).
- R2: With `wait_ack_i`=1, the engine does not stop after the DATA_W-th clock. The hold and the `irq_o` pulse move to the falling edge of the acknowledge clock, that is the clock after the data bits.
- R3: During the acknowledge clock, SDA is pulled low when the acknowledge enable is 1 (ACK) and released when it is 0 (NACK). SDA does not change while SCL is high in a data or acknowledge bit.
- R4: While held after the data bits, changes to `ack_en_i` appear on SDA within a few cycles. Changes to `ack_en_i` and `wait_ack_i` made there govern the acknowledge clock that follows the release.
- R5: A release strobe has no effect unless the engine is held. A stop request has no effect unless the engine is held after the acknowledge clock. A byte-start strobe has no effect while busy.
- R6: On a stop request, the engine pulls SDA low with SCL low, then releases SCL and keeps SDA low for as long as the bus SCL stays low.
- R7: SDA is released while SCL is high, no earlier than the setup count (SETUP_FAST when `mode_fast_i`=1, SETUP_STD when it is 0) and no later than that count plus SYNC_STAGES+4 cycles after the bus SCL rises.
- R8: `busy_o` rises with a byte start and stays high until the cycle in which the stop condition releases SDA.
- R9: With `wait_ack_i`=0 at the acknowledge clock, the next byte starts right after the acknowledge clock with no hold and no interrupt in between.
- R10: After reset, SCL and SDA are released, `busy_o` is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line level |
| sda_i | input | 1 | Sampled bus data line level |
| mode_fast_i | input | 1 | 1 selects fast-mode half period and stop setup count |
| ack_en_i | input | 1 | 1 answers ACK in the acknowledge clock, 0 answers NACK |
| wait_ack_i | input | 1 | Hold point: 0 after the data bits, 1 after the acknowledge clock |
| release_i | input | 1 | One-cycle strobe that ends a hold |
| stop_req_i | input | 1 | One-cycle strobe asking for a stop condition (held after acknowledge only) |
| byte_go_i | input | 1 | One-cycle strobe that starts reception from idle |
| scl_pull_o | output | 1 | 1 pulls the bus clock line low |
| sda_pull_o | output | 1 | 1 pulls the bus data line low |
| irq_o | output | 1 | One-cycle pulse on entering a hold |
| busy_o | output | 1 | High from byte start until stop completes |
| rx_data_o | output | DATA_W | Received byte, stable while held |

## Verification
The hardest case to reach is a stop request issued while the slave is still holding SCL low. The stop must then wait on the real bus level, and the setup count must begin only when SCL rises.

The bench reaches this case with a slave model that asserts its own clock pull-down during the hold after the acknowledge clock. It keeps that pull-down for a long stretch after the stop strobe, then counts clocks from its own release to the SDA rise.

A second hard case is a change of response and hold point in the middle of a hold. The bench turns an ACK into a NACK while held after the data bits, and the slave model records the level it sees on the acknowledge clock.

// File: rtl/iic_mrx_pkg.sv
package iic_mrx_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_LOW,
      ST_RISE,
      ST_HIGH,
      ST_HOLD_D,
      ST_HOLD_A,
      ST_SP_PRE,
      ST_SP_WAIT,
      ST_SP_SETUP
   } mrx_state_e;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned umin(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/iic_mrx_sync.sv
module iic_mrx_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES > 4) begin : g_bad_stages
         $error("iic_mrx_sync: STAGES must be 0 to 4");
      end

      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= {STAGES{RST_VAL}};
            end else if (STAGES == 1) begin
               sh_q[0] <= d_i;
            end else begin
               sh_q <= {sh_q[STAGES-2:0], d_i};
            end
         end
         assign q_o = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/iic_mrx_timer.sv
module iic_mrx_timer #(
   parameter int unsigned W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

   AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/iic_mrx_shift.sv
module iic_mrx_shift #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              bit_i,
   output logic [DATA_W-1:0] data_o
);

   logic [DATA_W-1:0] sr_q;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("iic_mrx_shift: DATA_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (en_i) begin
         sr_q <= {sr_q[DATA_W-2:0], bit_i};
      end
   end

   assign data_o = sr_q;

   AST_SHIFT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(sr_q)); // R1

endmodule

// File: rtl/iic_mrx_engine.sv
module iic_mrx_engine
   import iic_mrx_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HALF_STD    = 1000,
   parameter int unsigned HALF_FAST   = 250,
   parameter int unsigned SETUP_STD   = 800,
   parameter int unsigned SETUP_FAST  = 120
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              mode_fast_i,
   input  logic              ack_en_i,
   input  logic              wait_ack_i,
   input  logic              release_i,
   input  logic              stop_req_i,
   input  logic              byte_go_i,
   output logic              scl_pull_o,
   output logic              sda_pull_o,
   output logic              irq_o,
   output logic              busy_o,
   output logic [DATA_W-1:0] rx_data_o
);

   localparam int unsigned BIT_W   = $clog2(DATA_W + 1);
   localparam int unsigned MAX_T   = umax(umax(HALF_STD, HALF_FAST), umax(SETUP_STD, SETUP_FAST));
   localparam int unsigned CNT_W   = $clog2(MAX_T + 1);
   localparam int unsigned SU_MIN  = umin(SETUP_STD, SETUP_FAST);
   localparam logic [BIT_W-1:0] ACK_POS  = BIT_W'(DATA_W);
   localparam logic [BIT_W-1:0] LAST_POS = BIT_W'(DATA_W - 1);

   generate
      if (HALF_STD < 1 || HALF_FAST < 1) begin : g_bad_half
         $error("iic_mrx_engine: half periods must be at least 1");
      end
      if (SETUP_STD < 1 || SETUP_FAST < 1) begin : g_bad_setup
         $error("iic_mrx_engine: setup counts must be at least 1");
      end
   endgenerate

   mrx_state_e       st_q, st_d;
   logic [BIT_W-1:0] bit_q, bit_d;
   logic             ack_q;
   logic             irq_q, irq_d;
   logic             scl_s, sda_s;
   logic             tmr_load, tmr_zero;
   logic [CNT_W-1:0] tmr_val, half_val, su_val;
   logic             shift_en;

   iic_mrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));

   iic_mrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   iic_mrx_timer #(.W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero));

   iic_mrx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .en_i(shift_en), .bit_i(sda_s), .data_o(rx_data_o));

   assign half_val = mode_fast_i ? CNT_W'(HALF_FAST - 1) : CNT_W'(HALF_STD - 1);
   assign su_val   = mode_fast_i ? CNT_W'(SETUP_FAST - 1) : CNT_W'(SETUP_STD - 1);

   always_comb begin
      st_d     = st_q;
      bit_d    = bit_q;
      tmr_load = 1'b0;
      tmr_val  = half_val;
      shift_en = 1'b0;
      irq_d    = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (byte_go_i) begin
               st_d     = ST_LOW;
               bit_d    = '0;
               tmr_load = 1'b1;
            end
         end
         ST_LOW: begin
            if (tmr_zero) st_d = ST_RISE;
         end
         ST_RISE: begin
            if (scl_s) begin
               st_d     = ST_HIGH;
               tmr_load = 1'b1;
               shift_en = (bit_q < ACK_POS);
            end
         end
         ST_HIGH: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               if (bit_q == ACK_POS) begin
                  if (wait_ack_i) begin
                     st_d  = ST_HOLD_A;
                     irq_d = 1'b1;
                  end else begin
                     st_d  = ST_LOW;
                     bit_d = '0;
                  end
               end else if (bit_q == LAST_POS) begin
                  bit_d = ACK_POS;
                  if (wait_ack_i) begin
                     st_d = ST_LOW;
                  end else begin
                     st_d  = ST_HOLD_D;
                     irq_d = 1'b1;
                  end
               end else begin
                  bit_d = BIT_W'(bit_q + 1'b1);
                  st_d  = ST_LOW;
               end
            end
         end
         ST_HOLD_D: begin
            if (release_i) begin
               st_d     = ST_LOW;
               tmr_load = 1'b1;
            end
         end
         ST_HOLD_A: begin
            if (stop_req_i) begin
               st_d     = ST_SP_PRE;
               tmr_load = 1'b1;
            end else if (release_i) begin
               st_d     = ST_LOW;
               bit_d    = '0;
               tmr_load = 1'b1;
            end
         end
         ST_SP_PRE: begin
            if (tmr_zero) st_d = ST_SP_WAIT;
         end
         ST_SP_WAIT: begin
            if (scl_s) begin
               st_d     = ST_SP_SETUP;
               tmr_load = 1'b1;
               tmr_val  = su_val;
            end
         end
         ST_SP_SETUP: begin
            if (tmr_zero) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         bit_q <= '0;
         irq_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         bit_q <= bit_d;
         irq_q <= irq_d;
      end
   end

   // response level is refreshed throughout the hold after the data bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
      end else if (st_q == ST_HOLD_D ||
                   (st_q == ST_HIGH && tmr_zero && bit_q == LAST_POS)) begin
         ack_q <= ack_en_i;
      end
   end

   assign scl_pull_o = (st_q == ST_LOW) || (st_q == ST_HOLD_D) ||
                       (st_q == ST_HOLD_A) || (st_q == ST_SP_PRE);

   assign sda_pull_o = (ack_q && bit_q == ACK_POS &&
                        (st_q == ST_LOW || st_q == ST_RISE ||
                         st_q == ST_HIGH || st_q == ST_HOLD_D)) ||
                       (st_q == ST_SP_PRE) || (st_q == ST_SP_WAIT) ||
                       (st_q == ST_SP_SETUP);

   assign irq_o  = irq_q;
   assign busy_o = (st_q != ST_IDLE);

   // checker state: cycles spent in the stop setup phase
   logic [CNT_W-1:0] su_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         su_cnt_q <= '0;
      end else if (st_q == ST_SP_SETUP) begin
         if (su_cnt_q != {CNT_W{1'b1}}) su_cnt_q <= su_cnt_q + 1'b1;
      end else begin
         su_cnt_q <= '0;
      end
   end

   AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HIGH && $past(st_q) == ST_HIGH) |-> $stable(sda_pull_o)); // R3

   AST_IRQ_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> scl_pull_o); // R1

   AST_HOLD_D_IGNORES_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HOLD_D && !release_i) |=> (st_q == ST_HOLD_D)); // R5

   AST_STOP_WAITS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SP_WAIT && !scl_s) |=> (st_q == ST_SP_WAIT && sda_pull_o)); // R6

   AST_SETUP_LONG_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && $past(st_q) == ST_SP_SETUP) |-> (su_cnt_q >= CNT_W'(SU_MIN))); // R7

   AST_BUSY_ENDS_WITH_SDA: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $fell(sda_pull_o)); // R8

endmodule

// File: tb/iic_mrx_engine_bench.sv
`timescale 1ns/1ps
module iic_mrx_engine_bench;

   localparam int unsigned DW  = 8;
   localparam int unsigned SYN = 2;
   localparam int unsigned HS  = 6;
   localparam int unsigned HF  = 4;
   localparam int unsigned SUS = 30;
   localparam int unsigned SUF = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_fast = 1'b0, ack_en = 1'b0, wait_ack = 1'b0;
   logic rel = 1'b0, stop_req = 1'b0, go = 1'b0;
   logic scl_pull, sda_pull, irq, busy;
   logic [DW-1:0] rx_data;
   logic scl_bus, sda_bus;
   logic slv_sda_low = 1'b0, slv_scl_hold = 1'b0;

   always #2.5 clk = ~clk;

   assign scl_bus = !(scl_pull || slv_scl_hold);
   assign sda_bus = !(sda_pull || slv_sda_low);

   iic_mrx_engine #(.DATA_W(DW), .SYNC_STAGES(SYN), .HALF_STD(HS), .HALF_FAST(HF),
                    .SETUP_STD(SUS), .SETUP_FAST(SUF)) u_iic_mrx_engine (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .mode_fast_i(mode_fast), .ack_en_i(ack_en), .wait_ack_i(wait_ack),
      .release_i(rel), .stop_req_i(stop_req), .byte_go_i(go),
      .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .irq_o(irq),
      .busy_o(busy), .rx_data_o(rx_data));

   int total = 0, bad = 0, irq_cnt = 0, ack_cnt = 0;
   bit done = 0;
   logic [DW-1:0] exp_irq_q[$];
   logic          exp_ack_q[$];
   logic [DW-1:0] slv_q[$];
   logic          slv_act = 1'b0;
   int            slv_pos = 0;
   logic [DW-1:0] slv_byte = '0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // scoreboard driver side
   task automatic expect_irq(input logic [DW-1:0] b); exp_irq_q.push_back(b); endtask
   task automatic expect_ack(input logic a); exp_ack_q.push_back(a); endtask

   task automatic start_slave();
      slv_byte = slv_q.pop_front();
      slv_pos  = 0;
      slv_act  = 1'b1;
   endtask

   task automatic pulse_go();  @(negedge clk); go = 1;       @(negedge clk); go = 0;       endtask
   task automatic pulse_rel(); @(negedge clk); rel = 1;      @(negedge clk); rel = 0;      endtask
   task automatic pulse_sp();  @(negedge clk); stop_req = 1; @(negedge clk); stop_req = 0; endtask
   task automatic idle(input int n); repeat (n) @(negedge clk); endtask
   task automatic wait_irqs(input int n); while (irq_cnt < n) @(negedge clk); endtask

   // slave model: presents data MSB first on SCL falling edges
   always @(negedge scl_bus) begin
      if (slv_act && slv_pos < DW) slv_sda_low = !slv_byte[DW-1-slv_pos];
      else                         slv_sda_low = 1'b0;
   end

   // slave model and acknowledge monitor on SCL rising edges
   always @(posedge scl_bus) begin
      if (slv_act) begin
         if (slv_pos == DW) begin
            ack_cnt++;
            if (exp_ack_q.size() == 0) check("R3 unexpected ack clock", 1, 0);
            else check("R3 ack level on bus", sda_bus, exp_ack_q.pop_front());
            if (sda_bus == 1'b0 && slv_q.size() > 0) begin
               slv_byte = slv_q.pop_front();
               slv_pos  = 0;
            end else begin
               slv_act = 1'b0;
               slv_pos = 0;
            end
         end else begin
            slv_pos++;
         end
      end
   end

   // scoreboard monitor: every hold interrupt carries the expected byte
   always @(negedge clk) begin
      if (rst_n && irq === 1'b1) begin
         irq_cnt++;
         if (exp_irq_q.size() == 0) check("R1 unexpected irq", 1, 0);
         else check("R1 R2 byte at hold", rx_data, exp_irq_q.pop_front());
      end
   end

   initial begin
      repeat (150000) @(negedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      int n;
      idle(5);
      check("R10 reset scl released", scl_bus, 1);
      check("R10 reset sda released", sda_bus, 1);
      check("R10 reset busy", busy, 0);
      check("R10 reset irq", irq, 0);
      rst_n = 1;
      idle(5);

      // R5: release while idle does nothing
      pulse_rel();
      idle(20);
      check("R5 release idle scl", scl_bus, 1);
      check("R5 release idle busy", busy, 0);

      // byte A: hold after data bits, then change response and hold point
      slv_q.push_back(8'hA5);
      start_slave();
      expect_irq(8'hA5); expect_irq(8'hA5); expect_ack(1'b1);
      wait_ack = 0; ack_en = 1; mode_fast = 0;
      pulse_go();
      check("R8 busy after start", busy, 1);
      wait_irqs(1);
      idle(30);
      check("R1 scl held after data bits", scl_bus, 0);
      check("R3 ack drive visible in hold", sda_bus, 0);
      check("R1 no ack clock yet", ack_cnt, 0);
      pulse_sp();
      pulse_go();
      idle(30);
      check("R5 stop ignored in data hold", scl_bus, 0);
      check("R5 busy kept", busy, 1);
      check("R5 no extra irq", irq_cnt, 1);
      ack_en = 0; wait_ack = 1;
      idle(3);
      check("R4 response change reaches sda", sda_bus, 1);
      pulse_rel();
      wait_irqs(2);
      check("R4 R2 nack clock before hold", ack_cnt, 1);

      // stop while slave stretches SCL
      slv_scl_hold = 1;
      idle(2);
      pulse_sp();
      idle(100);
      check("R6 sda low while scl stretched", sda_bus, 0);
      check("R6 busy while stretched", busy, 1);
      slv_scl_hold = 0;
      n = 0;
      while (sda_bus !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
      check("R7 std setup lower bound", (n >= SUS), 1);
      check("R7 std setup upper bound", (n <= SUS + SYN + 4), 1);
      check("R7 sda rises with scl high", scl_bus, 1);
      check("R8 busy cleared at stop", busy, 0);

      // bytes B1 B2: continuous reception with no hold after ACK
      slv_q.push_back(8'h3C); slv_q.push_back(8'hC3);
      start_slave();
      expect_irq(8'h3C); expect_ack(1'b0); expect_irq(8'hC3); expect_irq(8'hC3); expect_ack(1'b1);
      wait_ack = 0; ack_en = 1;
      pulse_go();
      wait_irqs(3);
      pulse_rel();
      wait_irqs(4);
      check("R9 next byte followed ack without hold", ack_cnt, 2);
      ack_en = 0; wait_ack = 1;
      pulse_rel();
      wait_irqs(5);
      mode_fast = 1;
      pulse_sp();
      while (scl_bus !== 1'b1) @(negedge clk);
      n = 0;
      while (sda_bus !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
      check("R7 fast setup lower bound", (n >= SUF), 1);
      check("R7 fast setup upper bound", (n <= SUF + SYN + 4), 1);
      check("R8 busy cleared fast", busy, 0);

      // bytes C1 C2: hold after acknowledge clock from the start
      slv_q.push_back(8'h81); slv_q.push_back(8'h7E);
      start_slave();
      expect_irq(8'h81); expect_ack(1'b0); expect_irq(8'h7E); expect_ack(1'b1);
      wait_ack = 1; ack_en = 1; mode_fast = 0;
      pulse_go();
      wait_irqs(6);
      check("R2 ack clock done before first hold", ack_cnt, 4);
      check("R2 scl held after ack clock", scl_bus, 0);
      ack_en = 0;
      pulse_rel();
      wait_irqs(7);
      pulse_go();
      idle(10);
      check("R5 start ignored while busy", irq_cnt, 7);
      pulse_sp();
      while (busy === 1'b1) @(negedge clk);
      check("R6 bus free after stop", sda_bus, 1);
      check("R6 scl free after stop", scl_bus, 1);
      check("R1 all expected holds seen", exp_irq_q.size(), 0);
      check("R3 all expected acks seen", exp_ack_q.size(), 0);
      idle(5);
      finish_run();
   end

endmodule